// File: doc/BRIEF.md
# Caption Line Selector for the Vertical Blanking Interval

This block decides which horizontal lines of a video field are handed to a caption data slicer. It watches separated vertical and horizontal sync pulses, both already synchronous to the system clock. A line counter is cleared by each vertical sync falling edge and advanced by each horizontal sync rising edge. A one-cycle slice strobe is raised on two lines of every field: a fixed caption line, and one line that software programs into a position register.

A second strobe marks the line on which the downstream slicer should build its reference threshold. Software picks that line (fixed, programmed, or both) and the field it applies to. At every vertical sync falling edge the block also decides whether the field is the first or the second of the frame. It does this from how recently a horizontal sync edge arrived, and it offers the result both as a port and as a readable status bit.

Software uses a small register port. It has two writable registers (caption position and slicer control) and one read-only status register.

Top module: `vbi_line_sel`

## Requirements
- R1: A vertical sync falling edge clears the line counter. Each later horizontal sync rising edge advances it by one, so the Nth horizontal edge after the clear is line N.
- R2: `slice_stb` is high for exactly one clock. That clock is the one after the clock in which the horizontal rising edge is seen, and only when that line equals position register bits [4:0]. A value of 0 selects no extra line.
- R3: The line given by parameter FIXED_LINE (default 21) raises `slice_stb` in every field, whatever the position register holds.
- R4: The counter saturates at 2^CNT_W-1 and never wraps, so no line beyond that point raises a strobe until the next vertical falling edge.
- R5: Position register bits [7:6] choose the reference line: 00 is the fixed line, 01 is the programmed line, and 10 or 11 is both.
- R6: `ref_stb` is raised only when control register bit 1 equals the field flag (0 = field 1, 1 = field 2) and the line is chosen by R5. It has the same timing as `slice_stb`.
- R7: At a vertical falling edge, the field flag becomes 1 if a horizontal rising edge was seen no more than HALF_LINE_CLKS clocks earlier, counting the same clock. Otherwise it becomes 0. It changes at no other time.
- R8: Reads return data one clock after the address. Address 0 is the position register, 1 the control register, 2 the status register with the field flag in bit 3 and zeros elsewhere, and 3 reads zero.
- R9: Writes to addresses 2 and 3 have no effect.
- R10: After reset, both strobes, the field flag and both writable registers are 0.
- R11: A horizontal rising edge in the same clock as a vertical falling edge is not counted, so the next horizontal edge is line 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| hsync_in | input | 1 | Separated horizontal sync, active high |
| vsync_in | input | 1 | Separated vertical sync, active high, falling edge starts a field |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Registered read data |
| slice_stb | output | 1 | One-cycle strobe for a line to be sliced |
| ref_stb | output | 1 | One-cycle strobe for the reference-threshold line |
| field_out | output | 1 | Current field flag (0 = field 1, 1 = field 2) |

## Verification
A line counter that is off by one moves both strobes to a neighbouring line. This shows at the ports within the same field, on the first programmed or fixed line. A counter that wraps instead of saturating gives an extra strobe on long fields, within about 2^CNT_W lines. A wrong field decision shows on the first read of the status register and in the presence or absence of `ref_stb` during the next field. A dropped or kept simultaneous edge (R11) shifts the very next line.

// File: rtl/vbi_pkg.sv
package vbi_pkg;
  localparam logic [1:0] ADDR_POS  = 2'd0;
  localparam logic [1:0] ADDR_CTRL = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;

  localparam int FIELD_BIT_CTRL = 1;
  localparam int FIELD_BIT_STAT = 3;

  typedef enum logic [1:0] {
    REF_FIXED = 2'b00,
    REF_PROG  = 2'b01,
    REF_BOTH0 = 2'b10,
    REF_BOTH1 = 2'b11
  } ref_sel_e;
endpackage

// File: rtl/vbi_edge.sv
module vbi_edge #(
  parameter bit RISING = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic sig_in,
  output logic edge_out
);
  logic prev_q;

  // Reset the history to the level that makes no edge appear right after reset
  always_ff @(posedge clk) begin
    if (rst) prev_q <= RISING;
    else     prev_q <= sig_in;
  end

  generate
    if (RISING) begin : g_rise
      assign edge_out = sig_in & ~prev_q;
    end else begin : g_fall
      assign edge_out = ~sig_in & prev_q;
    end
  endgenerate
endmodule

// File: rtl/vbi_line_counter.sv
module vbi_line_counter #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             adv,
  output logic [CNT_W-1:0] line_q
);
  localparam logic [CNT_W-1:0] MAX_LINE = {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst || clr)                   line_q <= '0;
    else if (adv && line_q != MAX_LINE) line_q <= line_q + 1'b1;
  end
endmodule

// File: rtl/vbi_field_tracker.sv
module vbi_field_tracker #(
  parameter int HALF_LINE_CLKS = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic h_edge,
  input  logic v_fall,
  output logic field_q
);
  localparam int SW = $clog2(HALF_LINE_CLKS + 1);
  localparam logic [SW-1:0] HALF = SW'(HALF_LINE_CLKS);

  logic [SW-1:0] since_q;

  // Clocks since the last horizontal edge, saturating at the half-line mark
  always_ff @(posedge clk) begin
    if (rst)                  since_q <= HALF;
    else if (h_edge)          since_q <= '0;
    else if (since_q != HALF) since_q <= since_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)         field_q <= 1'b0;
    else if (v_fall) field_q <= h_edge | (since_q < HALF);
  end
endmodule

// File: rtl/vbi_regs.sv
module vbi_regs
  import vbi_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       we,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  input  logic       field,
  output logic [7:0] pos_q,
  output logic [7:0] ctrl_q,
  output logic [7:0] rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q  <= '0;
      ctrl_q <= '0;
    end else if (we) begin
      if (addr == ADDR_POS)  pos_q  <= wdata;
      if (addr == ADDR_CTRL) ctrl_q <= wdata;
    end
  end

  logic [7:0] stat_w;
  always_comb begin
    stat_w = '0;
    stat_w[FIELD_BIT_STAT] = field;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else begin
      case (addr)
        ADDR_POS:  rdata <= pos_q;
        ADDR_CTRL: rdata <= ctrl_q;
        ADDR_STAT: rdata <= stat_w;
        default:   rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/vbi_line_match.sv
module vbi_line_match
  import vbi_pkg::*;
#(
  parameter int CNT_W      = 6,
  parameter int FIXED_LINE = 21
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             h_edge,
  input  logic             v_fall,
  input  logic [CNT_W-1:0] line_q,
  input  logic [7:0]       pos,
  input  logic             ref_field,
  input  logic             field,
  output logic             slice_stb,
  output logic             ref_stb
);
  localparam logic [CNT_W-1:0] MAX_LINE = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] FIX_L    = CNT_W'(FIXED_LINE);

  logic [CNT_W-1:0] line_next;
  logic             hit_fix, hit_prog, ref_line, take;
  ref_sel_e         sel;

  assign line_next = (line_q == MAX_LINE) ? MAX_LINE : line_q + 1'b1;
  assign hit_fix   = (line_next == FIX_L);
  assign hit_prog  = (line_next == CNT_W'(pos[4:0]));
  assign sel       = ref_sel_e'(pos[7:6]);
  assign take      = h_edge & ~v_fall;

  always_comb begin
    case (sel)
      REF_FIXED: ref_line = hit_fix;
      REF_PROG:  ref_line = hit_prog;
      default:   ref_line = hit_fix | hit_prog;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slice_stb <= 1'b0;
      ref_stb   <= 1'b0;
    end else begin
      slice_stb <= take & (hit_fix | hit_prog);
      ref_stb   <= take & ref_line & (field == ref_field);
    end
  end
endmodule

// File: rtl/vbi_line_sel.sv
module vbi_line_sel
  import vbi_pkg::*;
#(
  parameter int CNT_W          = 6,
  parameter int FIXED_LINE     = 21,
  parameter int HALF_LINE_CLKS = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       hsync_in,
  input  logic       vsync_in,
  input  logic       cfg_we,
  input  logic [1:0] cfg_addr,
  input  logic [7:0] cfg_wdata,
  output logic [7:0] cfg_rdata,
  output logic       slice_stb,
  output logic       ref_stb,
  output logic       field_out
);
  localparam int NSYNC = 2;

  logic [NSYNC-1:0] sync_w, edge_w;
  logic             h_edge, v_fall;
  logic [CNT_W-1:0] line_cnt;
  logic [7:0]       pos_q, ctrl_q;

  assign sync_w = {vsync_in, hsync_in};

  // Index 0: horizontal rising edge; index 1: vertical falling edge
  for (genvar i = 0; i < NSYNC; i++) begin : g_edge
    vbi_edge #(.RISING(i == 0)) u_edge (
      .clk(clk), .rst(rst), .sig_in(sync_w[i]), .edge_out(edge_w[i])
    );
  end

  assign h_edge = edge_w[0];
  assign v_fall = edge_w[1];

  vbi_line_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .clr(v_fall), .adv(h_edge), .line_q(line_cnt)
  );

  vbi_field_tracker #(.HALF_LINE_CLKS(HALF_LINE_CLKS)) u_fld (
    .clk(clk), .rst(rst), .h_edge(h_edge), .v_fall(v_fall), .field_q(field_out)
  );

  vbi_regs u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .field(field_out), .pos_q(pos_q), .ctrl_q(ctrl_q), .rdata(cfg_rdata)
  );

  vbi_line_match #(.CNT_W(CNT_W), .FIXED_LINE(FIXED_LINE)) u_match (
    .clk(clk), .rst(rst), .h_edge(h_edge), .v_fall(v_fall), .line_q(line_cnt),
    .pos(pos_q), .ref_field(ctrl_q[FIELD_BIT_CTRL]), .field(field_out),
    .slice_stb(slice_stb), .ref_stb(ref_stb)
  );
endmodule

// File: rtl/vbi_line_sel_chk.sv
module vbi_line_sel_chk #(
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             hsync_in,
  input logic             slice_stb,
  input logic             ref_stb,
  input logic             field_out,
  input logic             v_fall,
  input logic [CNT_W-1:0] line_cnt
);
  localparam logic [CNT_W-1:0] MAX_LINE = {CNT_W{1'b1}};

  // R1
  cnt_clear_chk: assert property (@(posedge clk) disable iff (rst)
    v_fall |=> line_cnt == '0);

  // R2
  slice_single_chk: assert property (@(posedge clk) disable iff (rst)
    slice_stb |=> !slice_stb);

  // R2
  slice_on_edge_chk: assert property (@(posedge clk) disable iff (rst)
    slice_stb |-> ($past(hsync_in) && !$past(hsync_in, 2)));

  // R4
  cnt_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (line_cnt == MAX_LINE && !v_fall) |=> line_cnt == MAX_LINE);

  // R6
  ref_in_slice_chk: assert property (@(posedge clk) disable iff (rst)
    ref_stb |-> slice_stb);

  // R7
  field_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !v_fall |=> $stable(field_out));

  // R10
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!slice_stb && !ref_stb && !field_out));
endmodule

bind vbi_line_sel vbi_line_sel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .hsync_in(hsync_in), .slice_stb(slice_stb),
  .ref_stb(ref_stb), .field_out(field_out), .v_fall(v_fall), .line_cnt(line_cnt)
);

// File: tb/sim_vbi_line_sel.sv
module sim_vbi_line_sel;
  localparam int CNT_W = 6;
  localparam int FIXED = 21;
  localparam int HALF  = 16;
  localparam int MAXL  = (1 << CNT_W) - 1;

  logic clk = 1'b0, rst = 1'b1;
  logic hsync = 1'b0, vsync = 1'b0;
  logic we = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic slice_stb, ref_stb, field_out;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  int bm_line = 0;
  bit bm_field = 1'b0;
  logic [7:0] bm_pos = '0, bm_ctrl = '0;

  always #10 clk = ~clk;

  vbi_line_sel #(.CNT_W(CNT_W), .FIXED_LINE(FIXED), .HALF_LINE_CLKS(HALF)) u0 (
    .clk(clk), .rst(rst), .hsync_in(hsync), .vsync_in(vsync),
    .cfg_we(we), .cfg_addr(addr), .cfg_wdata(wdata), .cfg_rdata(rdata),
    .slice_stb(slice_stb), .ref_stb(ref_stb), .field_out(field_out)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit exp_slice(input int l);
    return (l == FIXED) || (l == int'(bm_pos[4:0]));
  endfunction

  function automatic bit exp_ref(input int l);
    bit lf, lp, lok;
    lf = (l == FIXED);
    lp = (l == int'(bm_pos[4:0]));
    case (bm_pos[7:6])
      2'b00:   lok = lf;
      2'b01:   lok = lp;
      default: lok = lf || lp;
    endcase
    return lok && (bm_field == bm_ctrl[1]);
  endfunction

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
    if (a == 2'd0) bm_pos = d;
    if (a == 2'd1) bm_ctrl = d;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string req);
    @(negedge clk); addr = a;
    @(negedge clk);
    chk(rdata == exp, req, rdata, exp);
  endtask

  // One line: strobes are checked one clock after the edge, then must drop
  task automatic hline();
    bit es, er;
    @(negedge clk); hsync = 1'b1;
    bm_line = (bm_line == MAXL) ? MAXL : bm_line + 1;
    es = exp_slice(bm_line);
    er = exp_ref(bm_line);
    @(negedge clk);
    chk(slice_stb == es, "R2/R3 slice", slice_stb, es);
    chk(ref_stb == er, "R5/R6 ref", ref_stb, er);
    @(negedge clk); hsync = 1'b0;
    chk(!slice_stb && !ref_stb, "R2 one-cycle", slice_stb, 0);
    @(negedge clk);
  endtask

  // Horizontal edge, then vertical falling edge m clocks later
  task automatic vfall(input int m);
    bit ef;
    @(negedge clk); vsync = 1'b1;
    @(negedge clk); hsync = 1'b1;
    for (int i = 1; i <= m; i++) begin
      @(negedge clk);
      if (i == 1) hsync = 1'b0;
      if (i == m) vsync = 1'b0;
    end
    ef = (m <= HALF);
    @(negedge clk);
    chk(field_out == ef, "R7 field", field_out, ef);
    bm_field = ef;
    bm_line = 0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10
    chk(!slice_stb && !ref_stb && !field_out, "R10 outputs", field_out, 0);
    rd(2'd0, 8'h00, "R10 pos reg");
    rd(2'd1, 8'h00, "R10 ctrl reg");

    // R8 register readback
    wr(2'd0, 8'h45); rd(2'd0, 8'h45, "R8 pos");
    wr(2'd1, 8'hA6); rd(2'd1, 8'hA6, "R8 ctrl");
    rd(2'd3, 8'h00, "R8 addr3");

    // R1/R2/R3: programmed line 5, reference on both lines in field 2
    wr(2'd0, 8'h85); wr(2'd1, 8'h02);
    vfall(2);
    rd(2'd2, 8'h08, "R8 status field2");
    for (int i = 0; i < 25; i++) hline();

    // R9: writes to status and address 3 are ignored
    wr(2'd2, 8'hFF); wr(2'd3, 8'hFF);
    rd(2'd2, 8'h08, "R9 status write");
    rd(2'd0, 8'h85, "R9 pos kept");
    rd(2'd1, 8'h02, "R9 ctrl kept");
    chk(field_out == 1'b1, "R9 field kept", field_out, 1);

    // R7 field 1, reference on fixed line only in field 1, position 0
    wr(2'd0, 8'h00); wr(2'd1, 8'h00);
    vfall(30);
    rd(2'd2, 8'h00, "R8 status field1");
    for (int i = 0; i < 24; i++) hline();

    // R7 boundary: exactly HALF and HALF+1 clocks
    vfall(HALF);
    vfall(HALF + 1);

    // R4 saturation: long field, no wrap back onto line 21 or 31
    wr(2'd0, 8'h5F);
    vfall(40);
    for (int i = 0; i < 90; i++) hline();

    // R11: horizontal edge together with vertical falling edge
    wr(2'd0, 8'h41); wr(2'd1, 8'h02);
    @(negedge clk); vsync = 1'b1;
    @(negedge clk); hsync = 1'b1; vsync = 1'b0;
    @(negedge clk); hsync = 1'b0;
    chk(field_out == 1'b1, "R11 field same clock", field_out, 1);
    bm_field = 1'b1; bm_line = 0;
    hline();
    chk(bm_line == 1, "R11 first line", bm_line, 1);
    for (int i = 0; i < 22; i++) hline();

    // Random frames
    for (int f = 0; f < 40; f++) begin
      int m, n;
      wr(2'd0, 8'($urandom));
      wr(2'd1, 8'($urandom));
      m = $urandom_range(1, 40);
      vfall(m);
      rd(2'd2, {4'b0, bm_field, 3'b0}, "R8 status random");
      n = ($urandom_range(0, 7) == 0) ? 80 : $urandom_range(22, 40);
      for (int i = 0; i < n; i++) hline();
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule